// File: doc/BRIEF.md
# Paged Wiper Register Controller

This block sits behind a byte-level serial slave and owns the registers of a dual, two-wiper digital potentiometer: four volatile 8-bit wiper registers that drive the tap decoders, a status register that selects what the bus reaches, and a 4-by-4 array of data registers held in storage that keeps its contents across reset. The slave hands it events: the start of a transaction, each received byte, a request for a byte to send, and STOP. The first byte after a start is the address byte. The later bytes are data for the addressed register, and the address advances through a page of four slots.

Slot numbers give the page order: slot 0 is wiper 0A, slot 1 is wiper 1B, slot 2 is wiper 1A and slot 3 is wiper 0B. Address 7 is the status register. Any access to a data-register row copies that row into the wiper registers. This happens on a status write that selects a row, on data bytes written to a row, and on reads from a row. Data-register writes are held in a buffer until STOP. They commit only while write permission is high, and a commit starts a timed write cycle that locks out every request. A separate up/down port can ask to store one wiper into its level-0 data register.

Top module: `wiper_reg_ctrl`

## Requirements
- R1: After reset the status register reads 00h and the address pointer is 0. In the first clock after reset release, `busy` is high and the four wiper registers load from the level-0 data registers. `busy` is low from the next cycle on.
- R2: Only address-byte bits 2:0 are used. With status bit 0 clear, a data byte to address 0..3 writes the wiper at that slot, and slot s drives `wiperPos[8*s+7:8*s]`.
- R3: A data byte to address 7 stores bits 2:0 in the status register. Bit 0 selects the data registers and bits 2:1 select the level. Reserved bits 7:3 read as 0. When bit 0 of that byte is 1, all four wipers load from the selected level's data registers.
- R4: Each data byte to a slot advances the address by one, and address 3 wraps to 0. A fifth or later byte overwrites an earlier one.
- R5: With status bit 0 set, a data byte to a slot is written at once to that slot's wiper. Each wiper not yet written in the transaction loads from its stored row value.
- R6: Buffered data-register bytes are written to the selected level at STOP, and only if `wrAllow` is high. Otherwise they are discarded and no write cycle starts.
- R7: A commit raises `busy` for exactly WRITE_CYCLES clocks. While `busy` is high, starts, bytes, reads, STOPs and store requests are ignored.
- R8: A read returns the addressed register under the status selection: a wiper, a data register, the status register, or 00h for addresses 4..6. A read of slots 0..3 advances the address with 3-to-0 wrap. A read of any other address leaves the address unchanged.
- R9: A read of a slot while status bit 0 is set loads all four wipers from the selected row.
- R10: With `wrAllow` high, a store request copies the wiper at `storeSel` into its level-0 data register and starts a write cycle. With `wrAllow` low, the request does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrAllow | input | 1 | Write permission for data registers (high = allowed) |
| txnStart | input | 1 | Pulse: a write transaction begins; the next byte is the address byte |
| byteValid | input | 1 | Pulse: `byteIn` holds a received byte |
| byteIn | input | 8 | Received byte |
| rdReq | input | 1 | Pulse: the slave needs a byte to transmit |
| stopEv | input | 1 | Pulse: STOP seen on the bus |
| storeReq | input | 1 | Pulse: up/down port asks for a level-0 store |
| storeSel | input | 2 | Slot whose wiper is stored |
| rdData | output | 8 | Byte returned by the last read, valid the cycle after `rdReq` |
| busy | output | 1 | Recall or nonvolatile write cycle in progress |
| wiperPos | output | 32 | Four wiper codes, slot s at bits 8*s+7:8*s |

## Verification
Wiper and data-register contents are swept through every slot and every level. Each value is a linear function of level and slot, so any swap of slot order or level decode shows up as a wrong byte. Six-byte page writes that start mid-page and five-byte reads that start at slot 1 tell correct wrap from a missing or off-by-one increment. Transfers made with write permission low leave the wipers holding bytes that differ from the stored row. A later single-byte row write or row read then separates "reload from row" from "leave unchanged". A status write and a STOP sent during a write cycle, and store requests with permission low, are checked through the status readback, the `busy` output and later readback of the data registers.

// File: rtl/wiper_reg_pkg.sv
package wiper_reg_pkg;
  localparam int SLOTS = 4;
  localparam int SLOT_W = 2;
  localparam int LEVELS = 4;
  localparam int LVL_W = 2;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 3'd7;

  typedef struct packed {
    logic recall;
    logic ldAddr;
    logic wrData;
    logic doRead;
    logic stopSeen;
    logic commit;
    logic store;
  } ctlStrobeT;
endpackage

// File: rtl/wiper_reg_ctl.sv
module wiper_reg_ctl
  import wiper_reg_pkg::*;
#(
  parameter int WRITE_CYCLES = 500000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrAllow,
  input  logic      txnStart,
  input  logic      byteValid,
  input  logic      rdReq,
  input  logic      stopEv,
  input  logic      storeReq,
  input  logic      pendingAny,
  output ctlStrobeT stb,
  output logic      busy
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic recallPend;
  logic expectAddr;

  assign busy = recallPend | (cnt != '0);

  always_comb begin
    stb = '0;
    if (recallPend) begin
      stb.recall = 1'b1;
    end else if (cnt == '0) begin
      stb.ldAddr   = byteValid & expectAddr;
      stb.wrData   = byteValid & ~expectAddr;
      stb.doRead   = rdReq;
      stb.stopSeen = stopEv;
      stb.commit   = stopEv & pendingAny & wrAllow;
      stb.store    = storeReq & wrAllow & ~(stopEv & pendingAny & wrAllow);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt        <= '0;
      recallPend <= 1'b1;
      expectAddr <= 1'b0;
    end else begin
      recallPend <= 1'b0;
      if (!busy && txnStart) expectAddr <= 1'b1;
      else if (stb.ldAddr) expectAddr <= 1'b0;
      if (stb.commit || stb.store) cnt <= CNT_W'(WRITE_CYCLES);
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (stopEv && !busy && pendingAny && wrAllow) |=> busy); // R7
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R7
endmodule

// File: rtl/wiper_reg_dp.sv
module wiper_reg_dp
  import wiper_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobeT               stb,
  input  logic                    busy,
  input  logic                    wrAllow,
  input  logic [DATA_W-1:0]       byteIn,
  input  logic [SLOT_W-1:0]       storeSel,
  output logic [DATA_W-1:0]       rdData,
  output logic [SLOTS*DATA_W-1:0] wiperFlat,
  output logic                    pendingAny
);
  localparam int ST_W = LVL_W + 1;

  logic [DATA_W-1:0] wiper   [SLOTS];
  logic [DATA_W-1:0] pageBuf [SLOTS];
  logic [DATA_W-1:0] dr      [LEVELS][SLOTS];
  logic [SLOTS-1:0]  pageMask;
  logic [ADDR_W-1:0] addrReg;
  logic [ST_W-1:0]   statusReg;
  logic [DATA_W-1:0] rdValue;
  logic [LEVELS*SLOTS*DATA_W-1:0] drFlat;

  wire unusedHi = ^byteIn[DATA_W-1:ST_W];

  wire [SLOT_W-1:0] slotIdx  = addrReg[SLOT_W-1:0];
  wire              isSlot   = ~addrReg[ADDR_W-1];
  wire              isStatus = (addrReg == STATUS_ADDR);
  wire              nvSel    = statusReg[0];
  wire [LVL_W-1:0]  lvl      = statusReg[LVL_W:1];
  wire [LVL_W-1:0]  newLvl   = byteIn[LVL_W:1];
  wire [ADDR_W-1:0] nextAddr = {1'b0, SLOT_W'(slotIdx + 1'b1)};

  assign pendingAny = |pageMask;

  always_comb begin
    rdValue = '0;
    if (isStatus) rdValue[ST_W-1:0] = statusReg;
    else if (isSlot) rdValue = nvSel ? dr[lvl][slotIdx] : wiper[slotIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) begin
        wiper[i]   <= '0;
        pageBuf[i] <= '0;
      end
      pageMask  <= '0;
      addrReg   <= '0;
      statusReg <= '0;
      rdData    <= '0;
    end else begin
      if (stb.recall)
        for (int i = 0; i < SLOTS; i++) wiper[i] <= dr[0][i];
      if (stb.ldAddr) addrReg <= byteIn[ADDR_W-1:0];
      if (stb.wrData) begin
        if (isStatus) begin
          statusReg <= byteIn[ST_W-1:0];
          if (byteIn[0])
            for (int i = 0; i < SLOTS; i++) wiper[i] <= dr[newLvl][i];
        end else if (isSlot) begin
          addrReg <= nextAddr;
          if (!nvSel) begin
            wiper[slotIdx] <= byteIn;
          end else begin
            pageBuf[slotIdx]  <= byteIn;
            pageMask[slotIdx] <= 1'b1;
            for (int i = 0; i < SLOTS; i++) begin
              if (SLOT_W'(i) == slotIdx) wiper[i] <= byteIn;
              else if (!pageMask[i]) wiper[i] <= dr[lvl][i];
            end
          end
        end
      end
      if (stb.doRead) begin
        rdData <= rdValue;
        if (isSlot) begin
          addrReg <= nextAddr;
          if (nvSel)
            for (int i = 0; i < SLOTS; i++) wiper[i] <= dr[lvl][i];
        end
      end
      if (stb.stopSeen) pageMask <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.commit)
      for (int i = 0; i < SLOTS; i++)
        if (pageMask[i]) dr[lvl][i] <= pageBuf[i];
    if (stb.store) dr[0][storeSel] <= wiper[storeSel];
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_wout
    assign wiperFlat[g*DATA_W +: DATA_W] = wiper[g];
  end
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign drFlat[(l*SLOTS+s)*DATA_W +: DATA_W] = dr[l][s];
    end
  end

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(statusReg)); // R7
  AST_DR_PROTECT: assert property (@(posedge clk) disable iff (!rstN)
    !wrAllow |=> $stable(drFlat)); // R6
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doRead && isStatus) |=> (rdData[DATA_W-1:ST_W] == '0)); // R3
endmodule

// File: rtl/wiper_reg_ctrl.sv
module wiper_reg_ctrl
  import wiper_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrAllow,
  input  logic                    txnStart,
  input  logic                    byteValid,
  input  logic [DATA_W-1:0]       byteIn,
  input  logic                    rdReq,
  input  logic                    stopEv,
  input  logic                    storeReq,
  input  logic [SLOT_W-1:0]       storeSel,
  output logic [DATA_W-1:0]       rdData,
  output logic                    busy,
  output logic [SLOTS*DATA_W-1:0] wiperPos
);
  ctlStrobeT stb;
  logic pendingAny;

  wiper_reg_ctl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .wrAllow(wrAllow), .txnStart(txnStart),
    .byteValid(byteValid), .rdReq(rdReq), .stopEv(stopEv),
    .storeReq(storeReq), .pendingAny(pendingAny), .stb(stb), .busy(busy)
  );

  wiper_reg_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .wrAllow(wrAllow),
    .byteIn(byteIn), .storeSel(storeSel), .rdData(rdData),
    .wiperFlat(wiperPos), .pendingAny(pendingAny)
  );
endmodule

// File: tb/wiper_reg_ctrl_test.sv
module wiper_reg_ctrl_test;
  localparam int WC = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrAllow = 1'b1;
  logic txnStart = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteIn = '0;
  logic rdReq = 1'b0;
  logic stopEv = 1'b0;
  logic storeReq = 1'b0;
  logic [1:0] storeSel = '0;
  logic [7:0] rdData;
  logic busy;
  logic [31:0] wiperPos;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] rb;

  always #5 clk = ~clk;

  wiper_reg_ctrl #(.DATA_W(8), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rstN(rstN), .wrAllow(wrAllow), .txnStart(txnStart),
    .byteValid(byteValid), .byteIn(byteIn), .rdReq(rdReq), .stopEv(stopEv),
    .storeReq(storeReq), .storeSel(storeSel), .rdData(rdData), .busy(busy),
    .wiperPos(wiperPos)
  );

  function automatic logic [7:0] v(int l, int s);
    return 8'(33 + l * 64 + s * 11);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic startTxn();
    txnStart = 1'b1; cycle(); txnStart = 1'b0;
  endtask
  task automatic sendByte(logic [7:0] b);
    byteValid = 1'b1; byteIn = b; cycle(); byteValid = 1'b0;
  endtask
  task automatic stopTxn();
    stopEv = 1'b1; cycle(); stopEv = 1'b0;
  endtask
  task automatic rdOne(output logic [7:0] b);
    rdReq = 1'b1; cycle(); rdReq = 1'b0; b = rdData;
  endtask
  task automatic statusWrite(logic [7:0] b);
    startTxn(); sendByte(8'h07); sendByte(b); stopTxn();
  endtask
  task automatic setAddr(logic [7:0] a);
    startTxn(); sendByte(a); stopTxn();
  endtask
  task automatic waitIdle();
    while (busy) cycle();
  endtask
  task automatic doReset();
    rstN = 1'b0;
    repeat (3) cycle();
    rstN = 1'b1;
    check("R1 busy during recall", 32'(busy), 32'd1);
    cycle();
  endtask
  task automatic wp(int s, output logic [7:0] b);
    b = wiperPos[s*8 +: 8];
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL R7 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    check("R1 busy after recall", 32'(busy), 32'd0);
    check("R1 rdData reset", 32'(rdData), 32'h0);

    // R2 / R4: volatile wiper writes, upper address bits ignored, wrap
    startTxn(); sendByte(8'hA8);
    for (int s = 0; s < 4; s++) sendByte(8'(s * 19 + 5));
    stopTxn();
    for (int s = 0; s < 4; s++) begin
      wp(s, rb); check("R2 wiper slot write", 32'(rb), 32'(8'(s * 19 + 5)));
    end
    startTxn(); sendByte(8'hF2);
    for (int k = 0; k < 6; k++) sendByte(8'(8'h60 + k));
    stopTxn();
    check("R4 wrap overwrite", wiperPos, 32'h65646362);
    check("R4 no write cycle for wipers", 32'(busy), 32'd0);

    // R8: volatile reads with wrap
    setAddr(8'h01);
    for (int k = 0; k < 5; k++) begin
      rdOne(rb);
      check("R8 wiper read wrap", 32'(rb), 32'(8'h62 + ((k + 1) % 4)));
    end

    // R3: status with bit0 clear, reserved bits read 0
    statusWrite(8'hFC);
    setAddr(8'h07);
    rdOne(rb);
    check("R3 status readback", 32'(rb), 32'h04);
    rdOne(rb);
    check("R8 status read keeps address", 32'(rb), 32'h04);
    check("R3 no row copy when bit0 clear", wiperPos, 32'h65646362);
    setAddr(8'h05);
    rdOne(rb); check("R8 unused address", 32'(rb), 32'h0);
    rdOne(rb); check("R8 unused address again", 32'(rb), 32'h0);

    // R6 / R7: page write to every level
    for (int l = 0; l < 4; l++) begin
      statusWrite(8'(l * 2 + 1));
      startTxn(); sendByte(8'h00);
      for (int s = 0; s < 4; s++) sendByte(v(l, s));
      stopTxn();
      check("R6 commit starts write cycle", 32'(busy), 32'd1);
      if (l == 0) begin
        repeat (WC - 1) cycle();
        check("R7 busy held", 32'(busy), 32'd1);
        cycle();
        check("R7 busy length", 32'(busy), 32'd0);
      end
      if (l == 1) begin
        statusWrite(8'h00);
        check("R7 still busy", 32'(busy), 32'd1);
        waitIdle();
        setAddr(8'h07);
        rdOne(rb);
        check("R7 status write ignored when busy", 32'(rb), 32'h03);
      end
      waitIdle();
    end

    // R3 row copy on status write, R8 data register reads
    for (int l = 0; l < 4; l++) begin
      statusWrite(8'(l * 2 + 1));
      for (int s = 0; s < 4; s++) begin
        wp(s, rb); check("R3 row copied to wipers", 32'(rb), 32'(v(l, s)));
      end
      setAddr(8'h01);
      for (int k = 0; k < 4; k++) begin
        rdOne(rb);
        check("R8 data register read", 32'(rb), 32'(v(l, (k + 1) % 4)));
      end
    end

    // R5 / R6: discarded row write, then single-byte write reloads row
    statusWrite(8'h07);
    wrAllow = 1'b0;
    startTxn(); sendByte(8'h00);
    for (int s = 0; s < 4; s++) sendByte(8'(8'hA0 + s));
    stopTxn();
    check("R6 protected stop no cycle", 32'(busy), 32'd0);
    check("R5 bytes land in wipers", wiperPos, 32'hA3A2A1A0);
    wrAllow = 1'b1;
    startTxn(); sendByte(8'h02); sendByte(8'h5C);
    for (int s = 0; s < 4; s++) begin
      wp(s, rb);
      check("R5 unwritten wipers reload", 32'(rb), (s == 2) ? 32'h5C : 32'(v(3, s)));
    end
    stopTxn();
    check("R6 commit busy", 32'(busy), 32'd1);
    waitIdle();
    setAddr(8'h00);
    for (int s = 0; s < 4; s++) begin
      rdOne(rb);
      check("R6 stored row", 32'(rb), (s == 2) ? 32'h5C : 32'(v(3, s)));
    end

    // R9: read of a row moves it into the wipers
    statusWrite(8'h03);
    wrAllow = 1'b0;
    startTxn(); sendByte(8'h00);
    for (int s = 0; s < 4; s++) sendByte(8'h77);
    stopTxn();
    check("R5 protected bytes in wipers", wiperPos, 32'h77777777);
    wrAllow = 1'b1;
    setAddr(8'h00);
    rdOne(rb);
    check("R9 read data", 32'(rb), 32'(v(1, 0)));
    for (int s = 0; s < 4; s++) begin
      wp(s, rb); check("R9 row moved on read", 32'(rb), 32'(v(1, s)));
    end

    // R10: store requests
    statusWrite(8'h00);
    startTxn(); sendByte(8'h03); sendByte(8'h9D); stopTxn();
    wrAllow = 1'b0;
    storeSel = 2'd3; storeReq = 1'b1; cycle(); storeReq = 1'b0;
    check("R10 protected store no cycle", 32'(busy), 32'd0);
    wrAllow = 1'b1;
    statusWrite(8'h01);
    setAddr(8'h03);
    rdOne(rb);
    check("R10 protected store no change", 32'(rb), 32'(v(0, 3)));
    statusWrite(8'h00);
    startTxn(); sendByte(8'h03); sendByte(8'h9D); stopTxn();
    storeReq = 1'b1; cycle(); storeReq = 1'b0;
    check("R10 store starts cycle", 32'(busy), 32'd1);
    waitIdle();
    statusWrite(8'h01);
    setAddr(8'h03);
    rdOne(rb);
    check("R10 stored value", 32'(rb), 32'h9D);

    // R1: recall after second reset
    doReset();
    for (int s = 0; s < 4; s++) begin
      wp(s, rb);
      check("R1 recall level 0", 32'(rb), (s == 3) ? 32'h9D : 32'(v(0, s)));
    end
    rdOne(rb);
    check("R1 pointer and status reset", 32'(rb), 32'(v(0, 0)));

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule